// File: doc/BRIEF.md
# Burst Column Sequence Generator

This block predicts, beat by beat, which column a synchronous DRAM touches during a read or write burst. A controller or memory model presents a new access together with its starting column, the length code, the ordering type and the direction. From the next clock on, the block reports the column of each data beat, says whether that beat carries data, and flags the final beat of a fixed-length burst.

A fixed-length burst stays inside the aligned block of columns whose size is the burst length. Sequential ordering counts upward inside that block and wraps at its end. Interleaved ordering XORs the beat number into the low column bits. Full-page bursts step through the whole page, wrap from the top column to column 0 and run until a terminate arrives or a new access replaces them. A new access may be accepted on any clock and takes over at once.

The control is a three-state machine. `ST_IDLE` means no burst is running. `ST_BURST` runs a burst of 1, 2, 4 or 8 beats. `ST_PAGE` runs a full-page burst.

The machine has these transitions:
- IDLE→BURST and IDLE→PAGE on an accepted access, chosen by the decoded length.
- BURST→IDLE after the final beat, or on a terminate.
- PAGE→IDLE on a terminate.
- BURST or PAGE restarting into BURST or PAGE when a new access arrives during a running burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and whenever no burst is running, `beat_valid_o` and `last_o` are low and `col_o` is zero.
- R2: The length code decodes as 3'b000→1, 3'b001→2, 3'b010→4, 3'b011→8 and 3'b111→full page. Codes 3'b100, 3'b101 and 3'b110 act as length 1. Beat 0 appears in the cycle after `start_i` is sampled, and a fixed burst of length L shows beats 0..L-1 on consecutive cycles.
- R3: With sequential ordering (`interleave_i`=0) and fixed length L, beat n reports the column whose bits above log2(L) equal the start column's, and whose low log2(L) bits equal (start low bits + n) mod L.
- R4: With interleaved ordering (`interleave_i`=1) and fixed length L, beat n reports the start column with its low log2(L) bits XORed with n.
- R5: `last_o` is high exactly on beat L-1 of a fixed burst. If no new access is sampled on that beat, the next cycle has no valid beat.
- R6: A full-page burst reports start, start+1, and so on, wrapping from PAGE_COLS-1 to 0. It never raises `last_o` and keeps running until terminated or restarted.
- R7: Interleaved ordering combined with the full-page code is reserved and yields the sequential full-page order.
- R8: A write (`is_write_i`=1) with `single_wr_i`=1 is a single beat with `last_o` high, whatever the length code. Reads ignore `single_wr_i`.
- R9: With `term_i` high and no `start_i`, the running burst ends at that clock edge. During the terminate cycle a write beat is shown not valid (`beat_valid_o` low), while a read beat stays valid.
- R10: `start_i` is accepted in any cycle, including mid-burst and together with `term_i` (start wins). Beat 0 of the new burst, at the new start column, appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | A read or write access is accepted this cycle |
| is_write_i | input | 1 | The accepted access is a write |
| start_col_i | input | COL_W | Starting column of the access |
| blen_code_i | input | 3 | Burst length code (see R2) |
| interleave_i | input | 1 | 1 = interleaved ordering, 0 = sequential |
| single_wr_i | input | 1 | 1 = writes are single-location |
| term_i | input | 1 | Burst terminate this cycle |
| col_o | output | COL_W | Column of the current beat |
| beat_valid_o | output | 1 | Current beat carries data |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The hardest situation to reach is a full-page burst crossing the page boundary while other events hit its edges: a restart arriving on a final beat, and a terminate and a start landing on the same clock. The stimulus starts page bursts a few columns below the top column so that the wrap comes within a handful of cycles. It places restarts on the last beat and mid-burst, and pairs `start_i` with `term_i`. A behavioural model, built from integer arithmetic, predicts every output on every cycle.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;

    localparam logic [2:0] LEN_CODE_1    = 3'b000;
    localparam logic [2:0] LEN_CODE_2    = 3'b001;
    localparam logic [2:0] LEN_CODE_4    = 3'b010;
    localparam logic [2:0] LEN_CODE_8    = 3'b011;
    localparam logic [2:0] LEN_CODE_PAGE = 3'b111;
endpackage

// File: rtl/bcg_len_dec.sv
module bcg_len_dec
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [2:0]       code_i,
    input  logic             interleave_i,
    input  logic             is_write_i,
    input  logic             single_wr_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o,
    output logic             intl_o
);
    logic [COL_W-1:0] raw_mask;
    logic             raw_page;

    always_comb begin
        raw_page = 1'b0;
        unique case (code_i)
            LEN_CODE_1:    raw_mask = '0;
            LEN_CODE_2:    raw_mask = COL_W'(1);
            LEN_CODE_4:    raw_mask = COL_W'(3);
            LEN_CODE_8:    raw_mask = COL_W'(7);
            LEN_CODE_PAGE: begin
                raw_mask = '1;
                raw_page = 1'b1;
            end
            default:       raw_mask = '0;
        endcase
    end

    always_comb begin
        if (is_write_i && single_wr_i) begin
            mask_o = '0;
            page_o = 1'b0;
        end else begin
            mask_o = raw_mask;
            page_o = raw_page;
        end
        // reserved pairing: interleaved full page runs sequentially
        intl_o = interleave_i && !page_o;
    end
endmodule

// File: rtl/bcg_fsm.sv
module bcg_fsm
    import bcg_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_write_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             page_i,
    input  logic             intl_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] mask_o,
    output logic             intl_o,
    output logic             active_o,
    output logic             beat_valid_o,
    output logic             last_o
);
    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] cnt_q, mask_q, base_q;
    logic             intl_q, wr_q;
    logic             final_beat;

    assign final_beat = (cnt_q == mask_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = page_i ? ST_PAGE : ST_BURST;
            end
            ST_BURST: begin
                if (start_i)         state_d = page_i ? ST_PAGE : ST_BURST;
                else if (term_i)     state_d = ST_IDLE;
                else if (final_beat) state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (start_i)     state_d = page_i ? ST_PAGE : ST_BURST;
                else if (term_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mask_q  <= '0;
            base_q  <= '0;
            intl_q  <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                cnt_q  <= '0;
                mask_q <= mask_i;
                base_q <= start_col_i;
                intl_q <= intl_i;
                wr_q   <= is_write_i;
            end else if (state_q != ST_IDLE) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        active_o     = (state_q != ST_IDLE);
        beat_valid_o = active_o && !(term_i && wr_q);
        last_o       = (state_q == ST_BURST) && final_beat;
        base_o       = base_q;
        cnt_o        = cnt_q;
        mask_o       = mask_q;
        intl_o       = intl_q;
    end

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i) |=> (state_q == ST_IDLE)); // R9
    AST_PAGE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && !start_i && !term_i) |=> (state_q == ST_PAGE && !last_o)); // R6
endmodule

// File: rtl/bcg_col_calc.sv
module bcg_col_calc #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             intl_i,
    input  logic             active_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_col, xor_col, pick, merged;

    assign seq_col = base_i + cnt_i;
    assign xor_col = base_i ^ cnt_i;
    assign pick    = intl_i ? xor_col : seq_col;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign merged[b] = mask_i[b] ? pick[b] : base_i[b];
    end

    assign col_o = active_i ? merged : '0;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int PAGE_COLS = 1024,
    localparam int COL_W = $clog2(PAGE_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_write_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_code_i,
    input  logic             interleave_i,
    input  logic             single_wr_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_valid_o,
    output logic             last_o
);
    logic [COL_W-1:0] dec_mask, base, cnt, run_mask;
    logic             dec_page, dec_intl, run_intl, active;

    bcg_len_dec #(.COL_W(COL_W)) len_dec_i (
        .code_i       (blen_code_i),
        .interleave_i (interleave_i),
        .is_write_i   (is_write_i),
        .single_wr_i  (single_wr_i),
        .mask_o       (dec_mask),
        .page_o       (dec_page),
        .intl_o       (dec_intl)
    );

    bcg_fsm #(.COL_W(COL_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .is_write_i   (is_write_i),
        .term_i       (term_i),
        .start_col_i  (start_col_i),
        .mask_i       (dec_mask),
        .page_i       (dec_page),
        .intl_i       (dec_intl),
        .base_o       (base),
        .cnt_o        (cnt),
        .mask_o       (run_mask),
        .intl_o       (run_intl),
        .active_o     (active),
        .beat_valid_o (beat_valid_o),
        .last_o       (last_o)
    );

    bcg_col_calc #(.COL_W(COL_W)) col_calc_i (
        .base_i   (base),
        .cnt_i    (cnt),
        .mask_i   (run_mask),
        .intl_i   (run_intl),
        .active_i (active),
        .col_o    (col_o)
    );

    AST_RESTART_COL: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (col_o == $past(start_col_i))); // R10
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> (!last_o && col_o == '0)); // R5
    AST_SINGLE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && is_write_i && single_wr_i) |=> last_o); // R8
endmodule

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb_top;
    localparam int PAGE = 1024;
    localparam int CW   = $clog2(PAGE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          t_start = 0, t_wr = 0, t_il = 0, t_sw = 0, t_term = 0;
    logic [CW-1:0] t_col = '0;
    logic [2:0]    t_code = '0;
    logic [CW-1:0] col_o;
    logic          beat_valid_o, last_o;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    bit m_act = 0;
    bit m_wr = 0;
    bit m_il = 0;
    int m_s = 0;
    int m_len = 1;   // 0 means full page
    int m_n = 0;

    always #10 clk = ~clk;

    burst_col_gen #(.PAGE_COLS(PAGE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(t_start), .is_write_i(t_wr),
        .start_col_i(t_col), .blen_code_i(t_code), .interleave_i(t_il),
        .single_wr_i(t_sw), .term_i(t_term), .col_o(col_o),
        .beat_valid_o(beat_valid_o), .last_o(last_o)
    );

    function automatic int dec_len(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0;
        end else if (t_start) begin
            m_s   = int'(t_col);
            m_len = (t_wr && t_sw) ? 1 : dec_len(int'(t_code));
            m_il  = t_il && (m_len != 0);
            m_wr  = t_wr;
            m_n   = 0;
            m_act = 1;
        end else if (m_act) begin
            if (t_term) m_act = 0;
            else if (m_len != 0 && m_n == m_len - 1) m_act = 0;
            else m_n = m_n + 1;
        end
    end

    task automatic step(input bit st, input bit wr, input int col, input int code,
                        input bit il, input bit sw, input bit tm, input string tag);
        int e_col;
        bit e_v, e_l;
        @(negedge clk);
        t_start = st; t_wr = wr; t_col = CW'(col); t_code = 3'(code);
        t_il = il; t_sw = sw; t_term = tm;
        #1;
        e_col = 0; e_v = 0; e_l = 0;
        if (m_act) begin
            if (m_len == 0) e_col = (m_s + m_n) % PAGE;
            else if (m_il) e_col = (m_s / m_len) * m_len + ((m_s % m_len) ^ m_n);
            else e_col = (m_s / m_len) * m_len + ((m_s % m_len) + m_n) % m_len;
            e_v = !(tm && m_wr);
            e_l = (m_len != 0) && (m_n == m_len - 1);
        end
        checks++;
        if (int'(col_o) != e_col || beat_valid_o != e_v || last_o != e_l) begin
            fails++;
            $display("FAIL %s: col/valid/last actual %0d/%0b/%0b expected %0d/%0b/%0b",
                     tag, col_o, beat_valid_o, last_o, e_col, e_v, e_l);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic burst(input bit wr, input int col, input int code, input bit il,
                         input bit sw, input string tag);
        step(1, wr, col, code, il, sw, 0, tag);
        for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        idle(3, "R1");
        @(negedge clk) rst_n = 1'b1;
        idle(2, "R1");
        // R2 and R3: every code, sequential, several starts
        for (int c = 0; c < 8; c++) begin
            if (c != 7) begin
                burst(0, 5, c, 0, 0, "R2");
                burst(0, 14, c, 0, 0, "R3");
            end
        end
        burst(0, 1023, 3, 0, 0, "R3");
        // R4 interleaved
        for (int c = 1; c < 4; c++) begin
            burst(0, 6, c, 1, 0, "R4");
            burst(0, 99, c, 1, 0, "R4");
        end
        // R6 full page across the wrap, then terminate (read)
        step(1, 0, PAGE - 3, 7, 0, 0, 0, "R6");
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, 1, "R9");
        idle(2, "R9");
        // R7 interleaved full page falls back to sequential
        step(1, 0, PAGE - 2, 7, 1, 0, 0, "R7");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 1, "R7");
        idle(1, "R7");
        // R8 single-location writes; reads ignore the flag
        burst(1, 21, 3, 0, 1, "R8");
        burst(1, 21, 7, 1, 1, "R8");
        burst(0, 21, 2, 0, 1, "R8");
        burst(1, 21, 2, 1, 0, "R8");
        // R9 write terminate mid burst and page write terminate
        step(1, 1, 40, 3, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 1, "R9");
        idle(2, "R9");
        step(1, 1, 1022, 7, 0, 0, 0, "R9");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 1, "R9");
        idle(1, "R9");
        // R10 restart mid burst, on the last beat, and together with terminate
        step(1, 0, 8, 3, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, "R10");
        step(1, 0, 33, 2, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, "R10");
        step(1, 1, 500, 7, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 0, 0, 0, "R10");
        step(1, 0, 3, 1, 0, 0, 1, "R10");
        step(0, 0, 0, 0, 0, 0, 0, "R10");
        step(1, 0, 77, 2, 0, 0, 0, "R5");
        idle(6, "R5");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule